// File: doc/BRIEF.md
# Dual-Lane 16x16 Multiply-Accumulate Unit

This block performs two multiply-accumulate operations at the same time. Each lane takes two 16-bit operands. Each operand is the upper or lower half of one of two shared 32-bit source words, and each lane picks its halves on its own. The operands are multiplied as signed values, either as fractions or as integers. The product is widened to 40 bits. It then replaces the lane's accumulator, is added to it, or is discarded, according to a per-lane operation code. The update happens on the rising clock edge.

In the same edge, each lane can write an extracted copy of its updated accumulator to a destination:

- **Narrow extraction (16 bits):** lane 1 fills the upper half of a shared result word and lane 0 fills the lower half. Rounding is optional.
- **Wide extraction (32 bits):** lane 1 fills an odd register and lane 0 fills the paired even register.

A lane that does not extract leaves its destination untouched. Both 40-bit accumulators are always visible at the outputs.

Top module: `dual_mac_unit`

## Requirements
- R1: While rst_n is low, both accumulators and all result outputs (res_word, res_even, res_odd) are cleared to zero at the clock edge.
- R2: A lane operand is bits [31:16] of its source word when its select input is 1, and bits [15:0] when it is 0. The four selects are independent, so either lane may use any pair of halves.
- R3: With int_mode = 0 (fractional), the signed product is sign-extended to 40 bits and shifted left by one. For example, 0x8000 times 0x8000 gives +0x0080000000.
- R4: With int_mode = 1 (integer), the sign-extended product is used without a shift. For the same operands, the integer product is therefore half the fractional one.
- R5: The lane operation codes act at the rising edge. 2'b00 holds the accumulator, 2'b01 loads it with the product, 2'b10 adds the product to it, and 2'b11 holds it. The sum wraps modulo 2^40.
- R6: A narrow fractional extraction yields bits [31:16] of the updated accumulator. When rnd_en is 1, 0x8000 is first added to its low 32 bits.
- R7: A narrow integer extraction yields bits [15:0] of the updated accumulator, and rnd_en has no effect on it.
- R8: In narrow extraction (ext_wide = 0), lane 1 writes res_word[31:16] and lane 0 writes res_word[15:0]. The value reflects the accumulator update of the same edge.
- R9: In wide extraction (ext_wide = 1), lane 1 writes bits [31:0] of its updated accumulator to res_odd and lane 0 writes to res_even, without rounding.
- R10: A lane whose extract enable is 0 leaves its destination unchanged. An extraction of one width leaves the other width's outputs of that lane unchanged.
- R11: acc0 and acc1 show the full 40-bit accumulators of lane 0 and lane 1, including the 8-bit extension in bits [39:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| l0_hi_a | input | 1 | Lane 0 takes the upper half of src_a when 1 |
| l0_hi_b | input | 1 | Lane 0 takes the upper half of src_b when 1 |
| l1_hi_a | input | 1 | Lane 1 takes the upper half of src_a when 1 |
| l1_hi_b | input | 1 | Lane 1 takes the upper half of src_b when 1 |
| int_mode | input | 1 | 1 = integer multiply and extraction, 0 = fractional |
| l0_acc_op | input | 2 | Lane 0 accumulator operation (hold, load, add) |
| l1_acc_op | input | 2 | Lane 1 accumulator operation (hold, load, add) |
| l0_ext_en | input | 1 | Lane 0 writes its destination this edge |
| l1_ext_en | input | 1 | Lane 1 writes its destination this edge |
| ext_wide | input | 1 | 1 = 32-bit register-pair extraction, 0 = 16-bit halves |
| rnd_en | input | 1 | Add 0x8000 before a narrow fractional extraction |
| res_word | output | 32 | Narrow destination: lane 1 upper half, lane 0 lower half |
| res_even | output | 32 | Wide destination of lane 0 |
| res_odd | output | 32 | Wide destination of lane 1 |
| acc0 | output | 40 | Lane 0 accumulator |
| acc1 | output | 40 | Lane 1 accumulator |

## Verification
A wrong accumulator shows on acc0 or acc1 one edge after the operation that corrupts it. Because the accumulator is not cleared between operations, the error stays there until the next load. A wrong extraction path shows in the same edge on the lane's destination half or register. A stray write is caught in the first edge where a non-extracting lane's destination changes. Rounding carries and the modulo-2^40 wrap are exercised directly, because they only show in a few low or high bits.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
   typedef enum logic [1:0] {
      ACC_KEEP = 2'b00,
      ACC_LOAD = 2'b01,
      ACC_SUM  = 2'b10,
      ACC_IDLE = 2'b11
   } acc_op_e;

   localparam int LANES = 2;
endpackage

// File: rtl/dmac_half_sel.sv
`timescale 1ns/1ps
module dmac_half_sel #(
   parameter int OP_W = 16
) (
   input  logic [2*OP_W-1:0] word_i,
   input  logic              hi_i,
   output logic [OP_W-1:0]   half_o
);
   always_comb begin
      half_o = hi_i ? word_i[2*OP_W-1:OP_W] : word_i[OP_W-1:0];
   end
endmodule

// File: rtl/dmac_mult.sv
`timescale 1ns/1ps
module dmac_mult #(
   parameter int OP_W  = 16,
   parameter int ACC_W = 40
) (
   input  logic [OP_W-1:0]  a_i,
   input  logic [OP_W-1:0]  b_i,
   input  logic             int_mode_i,
   output logic [ACC_W-1:0] prod_o
);
   localparam int PW  = 2 * OP_W;
   localparam int EXT = ACC_W - PW;

   logic signed [PW-1:0] raw;
   logic [ACC_W-1:0]     widened;

   always_comb begin
      raw = $signed(a_i) * $signed(b_i);
   end

   generate
      if (EXT > 0) begin : g_sext
         always_comb widened = {{EXT{raw[PW-1]}}, raw};
      end else begin : g_trunc
         always_comb widened = raw[ACC_W-1:0];
      end
   endgenerate

   always_comb begin
      prod_o = int_mode_i ? widened : (widened << 1);
   end
endmodule

// File: rtl/dmac_extract.sv
`timescale 1ns/1ps
module dmac_extract #(
   parameter int OP_W  = 16,
   parameter int ACC_W = 40
) (
   input  logic [ACC_W-1:0]  value_i,
   input  logic              int_mode_i,
   input  logic              rnd_en_i,
   output logic [OP_W-1:0]   half_o,
   output logic [2*OP_W-1:0] word_o
);
   localparam int RW = 2 * OP_W;
   localparam logic [RW-1:0] RND_K = RW'(1) << (OP_W - 1);

   logic [RW-1:0] rounded;

   always_comb begin
      rounded = value_i[RW-1:0] + (rnd_en_i ? RND_K : '0);
      half_o  = int_mode_i ? value_i[OP_W-1:0] : rounded[RW-1:OP_W];
      word_o  = value_i[RW-1:0];
   end
endmodule

// File: rtl/dmac_lane.sv
`timescale 1ns/1ps
module dmac_lane
   import dmac_pkg::*;
#(
   parameter int OP_W  = 16,
   parameter int ACC_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2*OP_W-1:0] src_a_i,
   input  logic [2*OP_W-1:0] src_b_i,
   input  logic              hi_a_i,
   input  logic              hi_b_i,
   input  logic              int_mode_i,
   input  logic              rnd_en_i,
   input  logic [1:0]        op_i,
   output logic [ACC_W-1:0]  acc_o,
   output logic [OP_W-1:0]   ext_half_o,
   output logic [2*OP_W-1:0] ext_word_o
);
   logic [OP_W-1:0]  opa, opb;
   logic [ACC_W-1:0] prod, acc_q, acc_d;
   acc_op_e          op;

   dmac_half_sel #(.OP_W(OP_W)) u_sel_a (.word_i(src_a_i), .hi_i(hi_a_i), .half_o(opa));
   dmac_half_sel #(.OP_W(OP_W)) u_sel_b (.word_i(src_b_i), .hi_i(hi_b_i), .half_o(opb));

   dmac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
      .a_i(opa), .b_i(opb), .int_mode_i(int_mode_i), .prod_o(prod)
   );

   always_comb begin
      op = acc_op_e'(op_i);
      unique case (op)
         ACC_LOAD: acc_d = prod;
         ACC_SUM:  acc_d = acc_q + prod;
         default:  acc_d = acc_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   dmac_extract #(.OP_W(OP_W), .ACC_W(ACC_W)) u_ext (
      .value_i(acc_d), .int_mode_i(int_mode_i), .rnd_en_i(rnd_en_i),
      .half_o(ext_half_o), .word_o(ext_word_o)
   );

   assign acc_o = acc_q;
endmodule

// File: rtl/dual_mac_unit.sv
`timescale 1ns/1ps
module dual_mac_unit
   import dmac_pkg::*;
#(
   parameter int OP_W  = 16,
   parameter int ACC_W = 40,
   localparam int SRC_W = 2 * OP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src_a,
   input  logic [SRC_W-1:0] src_b,
   input  logic             l0_hi_a,
   input  logic             l0_hi_b,
   input  logic             l1_hi_a,
   input  logic             l1_hi_b,
   input  logic             int_mode,
   input  logic [1:0]       l0_acc_op,
   input  logic [1:0]       l1_acc_op,
   input  logic             l0_ext_en,
   input  logic             l1_ext_en,
   input  logic             ext_wide,
   input  logic             rnd_en,
   output logic [SRC_W-1:0] res_word,
   output logic [SRC_W-1:0] res_even,
   output logic [SRC_W-1:0] res_odd,
   output logic [ACC_W-1:0] acc0,
   output logic [ACC_W-1:0] acc1
);
   generate
      if (ACC_W < SRC_W + 1) begin : g_bad_acc
         $error("ACC_W must exceed twice OP_W");
      end
      if (OP_W < 2) begin : g_bad_op
         $error("OP_W must be at least 2");
      end
   endgenerate

   logic             hi_a  [LANES];
   logic             hi_b  [LANES];
   logic [1:0]       op    [LANES];
   logic             ext   [LANES];
   logic [ACC_W-1:0] acc   [LANES];
   logic [OP_W-1:0]  half  [LANES];
   logic [SRC_W-1:0] word  [LANES];
   logic [OP_W-1:0]  half_q[LANES];
   logic [SRC_W-1:0] pair_q[LANES];

   always_comb begin
      hi_a[0] = l0_hi_a;   hi_a[1] = l1_hi_a;
      hi_b[0] = l0_hi_b;   hi_b[1] = l1_hi_b;
      op[0]   = l0_acc_op; op[1]   = l1_acc_op;
      ext[0]  = l0_ext_en; ext[1]  = l1_ext_en;
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         dmac_lane #(.OP_W(OP_W), .ACC_W(ACC_W)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .src_a_i(src_a), .src_b_i(src_b),
            .hi_a_i(hi_a[l]), .hi_b_i(hi_b[l]),
            .int_mode_i(int_mode), .rnd_en_i(rnd_en),
            .op_i(op[l]), .acc_o(acc[l]),
            .ext_half_o(half[l]), .ext_word_o(word[l])
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               half_q[l] <= '0;
               pair_q[l] <= '0;
            end else if (ext[l]) begin
               if (ext_wide) pair_q[l] <= word[l];
               else          half_q[l] <= half[l];
            end
         end
      end
   endgenerate

   assign res_word = {half_q[1], half_q[0]};
   assign res_even = pair_q[0];
   assign res_odd  = pair_q[1];
   assign acc0     = acc[0];
   assign acc1     = acc[1];
endmodule

// File: rtl/dmac_checker.sv
`timescale 1ns/1ps
module dmac_checker #(
   parameter int OP_W  = 16,
   parameter int ACC_W = 40,
   localparam int SRC_W = 2 * OP_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             int_mode,
   input logic [1:0]       l0_acc_op,
   input logic [1:0]       l1_acc_op,
   input logic             l0_ext_en,
   input logic             l1_ext_en,
   input logic             ext_wide,
   input logic [SRC_W-1:0] res_word,
   input logic [SRC_W-1:0] res_even,
   input logic [SRC_W-1:0] res_odd,
   input logic [ACC_W-1:0] acc0,
   input logic [ACC_W-1:0] acc1
);
   // R5
   lane0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l0_acc_op == 2'b00 || l0_acc_op == 2'b11) |=> acc0 == $past(acc0));
   // R5
   lane1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_acc_op == 2'b00 || l1_acc_op == 2'b11) |=> acc1 == $past(acc1));
   // R10
   lane0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !l0_ext_en |=> res_word[OP_W-1:0] == $past(res_word[OP_W-1:0])
                     && res_even == $past(res_even));
   // R10
   lane1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !l1_ext_en |=> res_word[SRC_W-1:OP_W] == $past(res_word[SRC_W-1:OP_W])
                     && res_odd == $past(res_odd));
   // R9
   even_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l0_ext_en && ext_wide) |=> res_even == acc0[SRC_W-1:0]);
   // R9
   odd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_ext_en && ext_wide) |=> res_odd == acc1[SRC_W-1:0]);
   // R7
   int_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l0_ext_en && !ext_wide && int_mode) |=> res_word[OP_W-1:0] == acc0[OP_W-1:0]);
   // R7
   int_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_ext_en && !ext_wide && int_mode) |=> res_word[SRC_W-1:OP_W] == acc1[OP_W-1:0]);
endmodule

bind dual_mac_unit dmac_checker #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .int_mode(int_mode),
   .l0_acc_op(l0_acc_op), .l1_acc_op(l1_acc_op),
   .l0_ext_en(l0_ext_en), .l1_ext_en(l1_ext_en), .ext_wide(ext_wide),
   .res_word(res_word), .res_even(res_even), .res_odd(res_odd),
   .acc0(acc0), .acc1(acc1)
);

// File: tb/dual_mac_unit_test.sv
`timescale 1ns/1ps
module dual_mac_unit_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] src_a, src_b;
   logic        l0_hi_a, l0_hi_b, l1_hi_a, l1_hi_b;
   logic        int_mode, l0_ext_en, l1_ext_en, ext_wide, rnd_en;
   logic [1:0]  l0_acc_op, l1_acc_op;
   logic [31:0] res_word, res_even, res_odd;
   logic [39:0] acc0, acc1;

   int total = 0;
   int bad   = 0;

   logic [31:0] exp_word, exp_even, exp_odd;

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic [3:0]  hi;    // {l1a, l1b, l0a, l0b}
      logic        im;
      logic [1:0]  op0;
      logic [1:0]  op1;
      logic        x0;
      logic        x1;
      logic        wide;
      logic        rnd;
      logic [39:0] e0;
      logic [39:0] e1;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{32'h0003_0005, 32'h0007_0004, 4'b1100, 1'b1, 2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 40'h14, 40'h15},
      '{32'h0003_0005, 32'h0007_0004, 4'b0110, 1'b1, 2'b10, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 40'h20, 40'h38},
      '{32'h4000_2000, 32'h4000_C000, 4'b1100, 1'b0, 2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 40'hFF_F000_0000, 40'h00_2000_0000},
      '{32'h4000_2000, 32'h4000_C000, 4'b1100, 1'b0, 2'b00, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 40'hFF_F000_0000, 40'h00_4000_0000},
      '{32'h8000_8000, 32'h8000_8000, 4'b1100, 1'b0, 2'b01, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 40'h00_8000_0000, 40'h00_8000_0000},
      '{32'h8000_8000, 32'h8000_8000, 4'b1100, 1'b1, 2'b11, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 40'h00_8000_0000, 40'h00_8000_0000}
   };

   dual_mac_unit uut (
      .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
      .l0_hi_a(l0_hi_a), .l0_hi_b(l0_hi_b), .l1_hi_a(l1_hi_a), .l1_hi_b(l1_hi_b),
      .int_mode(int_mode), .l0_acc_op(l0_acc_op), .l1_acc_op(l1_acc_op),
      .l0_ext_en(l0_ext_en), .l1_ext_en(l1_ext_en), .ext_wide(ext_wide), .rnd_en(rnd_en),
      .res_word(res_word), .res_even(res_even), .res_odd(res_odd),
      .acc0(acc0), .acc1(acc1)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // narrow extraction as R6/R7 define it
   function automatic logic [15:0] narrow(input logic [39:0] v, input logic im, input logic rnd);
      logic [31:0] s;
      s = v[31:0] + (rnd ? 32'h8000 : 32'h0);
      return im ? v[15:0] : s[31:16];
   endfunction

   task automatic apply(input vec_t v);
      src_a = v.a; src_b = v.b;
      {l1_hi_a, l1_hi_b, l0_hi_a, l0_hi_b} = v.hi;
      int_mode = v.im; l0_acc_op = v.op0; l1_acc_op = v.op1;
      l0_ext_en = v.x0; l1_ext_en = v.x1; ext_wide = v.wide; rnd_en = v.rnd;
      @(posedge clk);
      #2;
      if (v.x0) begin
         if (v.wide) exp_even = v.e0[31:0];
         else        exp_word[15:0] = narrow(v.e0, v.im, v.rnd);
      end
      if (v.x1) begin
         if (v.wide) exp_odd = v.e1[31:0];
         else        exp_word[31:16] = narrow(v.e1, v.im, v.rnd);
      end
   endtask

   initial begin
      #(20 * 5000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      src_a = 32'hFFFF_FFFF; src_b = 32'hFFFF_FFFF;
      {l1_hi_a, l1_hi_b, l0_hi_a, l0_hi_b} = 4'b0000;
      int_mode = 1'b0; l0_acc_op = 2'b01; l1_acc_op = 2'b01;
      l0_ext_en = 1'b1; l1_ext_en = 1'b1; ext_wide = 1'b0; rnd_en = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      check("R1 acc0", acc0, 40'h0);
      check("R1 acc1", acc1, 40'h0);
      check("R1 res_word", {8'h0, res_word}, 40'h0);
      check("R1 res_even", {8'h0, res_even}, 40'h0);
      check("R1 res_odd", {8'h0, res_odd}, 40'h0);
      exp_word = '0; exp_even = '0; exp_odd = '0;
      rst_n = 1'b1;

      // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11: table walk
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         check($sformatf("R11/R5 acc0 vec%0d", i), acc0, VECS[i].e0);
         check($sformatf("R11/R5 acc1 vec%0d", i), acc1, VECS[i].e1);
         check($sformatf("R8/R6/R7 word vec%0d", i), {8'h0, res_word}, {8'h0, exp_word});
         check($sformatf("R9/R10 even vec%0d", i), {8'h0, res_even}, {8'h0, exp_even});
         check($sformatf("R9/R10 odd vec%0d", i), {8'h0, res_odd}, {8'h0, exp_odd});
      end

      // R6 rounding carry: fractional 0x4000*0x0001 -> 0x8000
      apply('{32'h0000_4000, 32'h0000_0001, 4'b0000, 1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0,
              40'h8000, 40'h00_8000_0000});
      check("R3 acc0 small", acc0, 40'h8000);
      check("R6 no round", {24'h0, res_word[15:0]}, 40'h0000);
      apply('{32'h0000_4000, 32'h0000_0001, 4'b0000, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1,
              40'h8000, 40'h00_8000_0000});
      check("R6 round carry", {24'h0, res_word[15:0]}, 40'h0001);
      check("R10 lane1 half kept", {24'h0, res_word[31:16]}, {24'h0, exp_word[31:16]});

      // R5 wrap modulo 2^40 on lane 1: 512 adds of 2^31
      apply('{32'h8000_8000, 32'h8000_8000, 4'b1100, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0,
              40'h8000, 40'h00_8000_0000});
      for (int k = 0; k < 510; k++) begin
         apply('{32'h8000_8000, 32'h8000_8000, 4'b1100, 1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0,
                 40'h8000, 40'h0});
      end
      check("R5 near wrap", acc1, 40'hFF_8000_0000);
      apply('{32'h8000_8000, 32'h8000_8000, 4'b1100, 1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0,
              40'h8000, 40'h0});
      check("R5 wrapped", acc1, 40'h0);
      check("R5 lane0 held", acc0, 40'h8000);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule